// File: doc/BRIEF.md
# Direct-Mapped Instruction Word Cache

This block sits between a processor's 16-bit instruction-word fetch port and a 32-bit memory read port. It holds a small direct-mapped array of longword lines. Each line keeps a tag that is built from the upper fetch address bits plus the privilege level of the fetch. A fetch that hits is answered from the array. A fetch that misses fills the whole longword from memory and returns the addressed half of it.

If the fill read ends in a bus error, the line stays invalid and the fetch is served by a plain 16-bit read. When the enable input is low, every fetch goes straight to memory as a 16-bit read and the array is left untouched. A one-cycle invalidate-all input and the synchronous reset both empty the array.

Top module: `insn_cache`

## Requirements
- R1: After reset, `f_ack` and `m_req` are low and every line is invalid, so the first enabled fetch issues a 32-bit memory read.
- R2: A line is selected by fetch address bits [7:2]. Its tag is address bits [31:8] plus the privilege bit. A fetch whose tag differs from the stored tag of its line misses and replaces that line.
- R3: On an enabled miss, one memory read is issued with `m_long`=1 at the fetch address with bits [1:0] forced to 0. Once it completes without error, the line is valid.
- R4: The returned word is bits [31:16] of the longword when address bit 1 is 0, and bits [15:0] when address bit 1 is 1.
- R5: An enabled hit raises `f_ack` in the cycle after the request is accepted. It issues no memory read and returns the cached word, even if memory has changed since the fill.
- R6: The same address fetched with `f_super`=1 and with `f_super`=0 uses distinct tags, so a change of privilege misses.
- R7: If a 32-bit fill read returns `m_berr`=1, the line stays invalid and a 16-bit read (`m_long`=0) is issued at the fetch address. The fetch returns `m_rdata[15:0]` of that read. A later fetch of the same address misses again.
- R8: With `cache_en` low, a fetch issues only a 16-bit read and never updates the array. A later enabled fetch of that address still misses.
- R9: A pulse on `inval_all` clears every valid flag in one cycle. A fetch in flight at that time still completes with the correct word.
- R10: `m_req` stays high, with `m_addr` and `m_long` stable, until `m_ack` is seen.
- R11: `f_ack` is a single-cycle pulse per accepted fetch, and `f_rdata` holds the fetched word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Cache enable; low bypasses the array |
| inval_all | input | 1 | Clears all valid flags |
| f_req | input | 1 | Fetch request, held until `f_ack` |
| f_addr | input | 32 | Fetch byte address |
| f_super | input | 1 | Fetch is made in supervisor state |
| f_ack | output | 1 | Fetch done pulse |
| f_rdata | output | 16 | Fetched instruction word |
| m_req | output | 1 | Memory read request |
| m_addr | output | 32 | Memory read address |
| m_long | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| m_ack | input | 1 | Memory read done |
| m_berr | input | 1 | Bus error with `m_ack` |
| m_rdata | input | 32 | Read data; 16-bit reads return in [15:0] |

## Verification
The assertions check the memory handshake on every cycle: requests stay stable until acknowledged, longword reads are aligned, and an erroring fill switches to a 16-bit read. They also check that each fetch acknowledge is a single pulse and that reset leaves both ports idle. Whether a fetch hit or missed, which half word came back, and whether privilege, bus errors, the disable input or invalidation left the array in the right state only show up across a sequence of fetches. The bench scenarios cover these by counting memory reads and by changing memory contents between fetches.

// File: rtl/insn_cache_pkg.sv
package insn_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WORD = 2'd2
  } ic_state_e;
endpackage

// File: rtl/ic_tag_store.sv
module ic_tag_store #(
  parameter int LINES = 64,
  parameter int TAG_W = 25,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inval,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] tags [LINES];
  logic [LINES-1:0] valid;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst || inval) begin
        valid[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tags[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        tags[g] <= wr_tag;
      end
    end
  end

  assign rd_tag   = tags[rd_idx];
  assign rd_valid = valid[rd_idx];
endmodule

// File: rtl/ic_data_store.sv
module ic_data_store #(
  parameter int LINES  = 64,
  parameter int LINE_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_data
);
  logic [LINE_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/ic_fill_ctrl.sv
module ic_fill_ctrl
  import insn_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int LINES  = 64,
  localparam int LINE_W = 2 * WORD_W,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_en,
  input  logic              f_req,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              f_super,
  output logic              f_ack,
  output logic [WORD_W-1:0] f_rdata,
  input  logic              hit,
  input  logic [LINE_W-1:0] hit_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [LINE_W-1:0] wr_data,
  output logic              m_req,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_long,
  input  logic              m_ack,
  input  logic              m_berr,
  input  logic [LINE_W-1:0] m_rdata
);
  ic_state_e         state;
  logic [ADDR_W-1:0] a_q;
  logic              s_q;

  function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] lw, input logic lo);
    return lo ? lw[WORD_W-1:0] : lw[LINE_W-1 -: WORD_W];
  endfunction

  assign wr_en   = (state == ST_FILL) && m_ack && !m_berr;
  assign wr_idx  = a_q[OFF_W +: IDX_W];
  assign wr_tag  = {s_q, a_q[ADDR_W-1:OFF_W+IDX_W]};
  assign wr_data = m_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      a_q     <= '0;
      s_q     <= 1'b0;
      f_ack   <= 1'b0;
      f_rdata <= '0;
      m_req   <= 1'b0;
      m_addr  <= '0;
      m_long  <= 1'b0;
    end else begin
      f_ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (f_req && !f_ack) begin
            a_q <= f_addr;
            s_q <= f_super;
            if (cache_en && hit) begin
              f_ack   <= 1'b1;
              f_rdata <= pick(hit_data, f_addr[1]);
            end else if (cache_en) begin
              m_req  <= 1'b1;
              m_addr <= {f_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
              m_long <= 1'b1;
              state  <= ST_FILL;
            end else begin
              m_req  <= 1'b1;
              m_addr <= f_addr;
              m_long <= 1'b0;
              state  <= ST_WORD;
            end
          end
        end
        ST_FILL: begin
          if (m_ack) begin
            if (!m_berr) begin
              f_ack   <= 1'b1;
              f_rdata <= pick(m_rdata, a_q[1]);
              m_req   <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              m_addr <= a_q;
              m_long <= 1'b0;
              state  <= ST_WORD;
            end
          end
        end
        ST_WORD: begin
          if (m_ack) begin
            f_ack   <= 1'b1;
            f_rdata <= m_rdata[WORD_W-1:0];
            m_req   <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/insn_cache.sv
module insn_cache #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int LINES  = 64,
  localparam int LINE_W = 2 * WORD_W,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_en,
  input  logic              inval_all,
  input  logic              f_req,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              f_super,
  output logic              f_ack,
  output logic [WORD_W-1:0] f_rdata,
  output logic              m_req,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_long,
  input  logic              m_ack,
  input  logic              m_berr,
  input  logic [LINE_W-1:0] m_rdata
);
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [TAG_W-1:0]  st_tag;
  logic              st_valid;
  logic [LINE_W-1:0] st_data;
  logic              hit;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [LINE_W-1:0] wr_data;

  assign lk_idx = f_addr[OFF_W +: IDX_W];
  assign lk_tag = {f_super, f_addr[ADDR_W-1:OFF_W+IDX_W]};
  assign hit    = st_valid && (st_tag == lk_tag);

  ic_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .inval(inval_all),
    .rd_idx(lk_idx), .rd_tag(st_tag), .rd_valid(st_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag)
  );

  ic_data_store #(.LINES(LINES), .LINE_W(LINE_W)) u_data (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_data(st_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  ic_fill_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINES(LINES)) u_ctrl (
    .clk(clk), .rst(rst), .cache_en(cache_en),
    .f_req(f_req), .f_addr(f_addr), .f_super(f_super),
    .f_ack(f_ack), .f_rdata(f_rdata),
    .hit(hit), .hit_data(st_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .m_req(m_req), .m_addr(m_addr), .m_long(m_long),
    .m_ack(m_ack), .m_berr(m_berr), .m_rdata(m_rdata)
  );
endmodule

// File: rtl/insn_cache_chk.sv
module insn_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              f_ack,
  input logic              m_req,
  input logic [ADDR_W-1:0] m_addr,
  input logic              m_long,
  input logic              m_ack,
  input logic              m_berr
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!f_ack && !m_req));

  // R3
  long_align_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_long) |-> (m_addr[1:0] == 2'b00));

  // R7
  berr_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_ack && m_berr && m_long) |=> (m_req && !m_long));

  // R10
  mreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_long)));

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    f_ack |=> !f_ack);

  // R5
  ack_idle_mem_chk: assert property (@(posedge clk) disable iff (rst)
    f_ack |-> !m_req);
endmodule

bind insn_cache insn_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .f_ack(f_ack), .m_req(m_req), .m_addr(m_addr),
  .m_long(m_long), .m_ack(m_ack), .m_berr(m_berr)
);

// File: tb/tb_insn_cache.sv
`timescale 1ns/1ps
module tb_insn_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cache_en = 1'b1;
  logic        inval_all = 1'b0;
  logic        f_req = 1'b0;
  logic [31:0] f_addr = '0;
  logic        f_super = 1'b0;
  logic        f_ack;
  logic [15:0] f_rdata;
  logic        m_req;
  logic [31:0] m_addr;
  logic        m_long;
  logic        m_ack = 1'b0;
  logic        m_berr = 1'b0;
  logic [31:0] m_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int long_cnt = 0;
  int short_cnt = 0;
  logic [31:0] last_long = '0;
  logic [15:0] salt = 16'h3C5A;
  logic        berr_on = 1'b0;
  logic [31:0] berr_at = '0;
  int          lat = 0;
  logic [15:0] exp_q [$];
  string       req_q [$];

  always #2.5 clk = ~clk;

  insn_cache dut (
    .clk(clk), .rst(rst), .cache_en(cache_en), .inval_all(inval_all),
    .f_req(f_req), .f_addr(f_addr), .f_super(f_super),
    .f_ack(f_ack), .f_rdata(f_rdata),
    .m_req(m_req), .m_addr(m_addr), .m_long(m_long),
    .m_ack(m_ack), .m_berr(m_berr), .m_rdata(m_rdata)
  );

  function automatic logic [15:0] wd(input logic [31:0] a, input logic [15:0] s);
    return a[15:0] ^ a[31:16] ^ s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // memory model: acks after a fixed latency
  always @(posedge clk) begin
    if (m_ack) begin
      m_ack  <= 1'b0;
      m_berr <= 1'b0;
      lat    <= 0;
    end else if (m_req) begin
      if (lat == 2) begin
        m_ack <= 1'b1;
        lat   <= 0;
        if (m_long) begin
          long_cnt  <= long_cnt + 1;
          last_long <= m_addr;
          m_berr    <= berr_on && (m_addr == berr_at);
          m_rdata   <= {wd(m_addr, salt), wd(m_addr + 32'd2, salt)};
        end else begin
          short_cnt <= short_cnt + 1;
          m_berr    <= 1'b0;
          m_rdata   <= {16'h0, wd({m_addr[31:1], 1'b0}, salt)};
        end
      end else begin
        lat <= lat + 1;
      end
    end
  end

  // monitor: scoreboard compare of returned words (R4, R11)
  always @(negedge clk) begin
    if (!rst && f_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected f_ack", 1, 0);
      end else begin
        logic [15:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(f_rdata == e, r, "f_rdata", f_rdata, e);
      end
    end
  end

  task automatic fetch(input logic [31:0] a, input logic s, input logic [15:0] e,
                       input int el, input int es, input string req);
    int l0;
    int s0;
    int waitc;
    l0 = long_cnt;
    s0 = short_cnt;
    waitc = 0;
    exp_q.push_back(e);
    req_q.push_back(req);
    @(negedge clk);
    f_addr  = a;
    f_super = s;
    f_req   = 1'b1;
    forever begin
      @(negedge clk);
      waitc++;
      if (f_ack || waitc > 200) break;
    end
    if (waitc > 200) chk(1'b0, req, "fetch timeout", waitc, 0);
    f_req = 1'b0;
    chk(long_cnt - l0 == el, req, "32-bit reads", long_cnt - l0, el);
    chk(short_cnt - s0 == es, req, "16-bit reads", short_cnt - s0, es);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] old_salt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(f_ack == 1'b0, "R1", "f_ack after reset", f_ack, 0);
    chk(m_req == 1'b0, "R1", "m_req after reset", m_req, 0);
    // R1/R3: first fetch misses, aligned long read
    fetch(32'h0000_1000, 1'b0, wd(32'h1000, salt), 1, 0, "R1");
    chk(last_long == 32'h1000, "R3", "fill address", last_long, 32'h1000);
    // R4/R5: other half hits
    fetch(32'h0000_1002, 1'b0, wd(32'h1002, salt), 0, 0, "R5");
    // R3/R4: bit1 set, address aligned down
    fetch(32'h0000_2006, 1'b0, wd(32'h2006, salt), 1, 0, "R4");
    chk(last_long == 32'h2004, "R3", "aligned fill address", last_long, 32'h2004);
    // R5: hit returns cached word after memory changes
    old_salt = salt;
    salt = 16'h9911;
    fetch(32'h0000_1000, 1'b0, wd(32'h1000, old_salt), 0, 0, "R5");
    // R6: supervisor fetch of same address misses
    fetch(32'h0000_1000, 1'b1, wd(32'h1000, salt), 1, 0, "R6");
    fetch(32'h0000_1000, 1'b1, wd(32'h1000, salt), 0, 0, "R6");
    fetch(32'h0000_1000, 1'b0, wd(32'h1000, salt), 1, 0, "R6");
    // R2: same line, different upper bits
    fetch(32'h0000_1100, 1'b0, wd(32'h1100, salt), 1, 0, "R2");
    fetch(32'h0000_1102, 1'b0, wd(32'h1102, salt), 0, 0, "R2");
    fetch(32'h0000_1000, 1'b0, wd(32'h1000, salt), 1, 0, "R2");
    // R7: bus error during fill
    berr_on = 1'b1;
    berr_at = 32'h0000_3008;
    fetch(32'h0000_300A, 1'b0, wd(32'h300A, salt), 1, 1, "R7");
    berr_on = 1'b0;
    fetch(32'h0000_300A, 1'b0, wd(32'h300A, salt), 1, 0, "R7");
    fetch(32'h0000_3008, 1'b0, wd(32'h3008, salt), 0, 0, "R7");
    // R8: disabled fetches bypass and do not fill
    cache_en = 1'b0;
    fetch(32'h0000_4002, 1'b0, wd(32'h4002, salt), 0, 1, "R8");
    fetch(32'h0000_3008, 1'b0, wd(32'h3008, salt), 0, 1, "R8");
    cache_en = 1'b1;
    fetch(32'h0000_4002, 1'b0, wd(32'h4002, salt), 1, 0, "R8");
    // R9: invalidate while a fill is in flight
    fork
      fetch(32'h0000_5000, 1'b0, wd(32'h5000, salt), 1, 0, "R9");
      begin
        repeat (2) @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
      end
    join
    fetch(32'h0000_300A, 1'b0, wd(32'h300A, salt), 1, 0, "R9");
    fetch(32'h0000_4000, 1'b0, wd(32'h4000, salt), 1, 0, "R9");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "pending acks", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule